// File: doc/BRIEF.md
# Interleaved Multi-Lane rANS Encoder Front End

This block spreads one stream of symbols over several rANS encoder lanes that work side by side, and gathers their 16-bit output words back into one stream. Symbols are handed out in strict rotation: the first symbol after reset or after a flush goes to lane 0, the next to lane 1, and so on. Each lane owns its coder state and a small word queue. Each lane handles its own renormalization, so no lane ever waits on another and a decoder can rebuild every lane on its own.

Every output word carries the number of the lane that produced it. A flush command makes every lane write out its final state. When all those words have left the block, a done flag is raised. The lane model is behavioural. It uses a uniform probability model: every symbol value has frequency 2^(PROB_BITS-SYM_W). The model still produces a real, decodable state update and a real renormalization schedule.

Top module: `rans_interleave_enc`

## Requirements
- R1: After reset `sym_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: The k-th symbol accepted since reset or since the last accepted flush goes to lane k mod N_LANES.
- R3: A lane state starts at 0x0001_0000. For each symbol s, if state >= 2^(32-SYM_W) the lane first emits state[15:0] and shifts state right by 16 bits. Then state becomes (state >> F) * 2^PROB_BITS + s * 2^F + (state mod 2^F), where F = PROB_BITS - SYM_W.
- R4: An accepted flush makes every lane emit state[15:0] and then state[31:16]. It then resets every lane state to 0x0001_0000 and returns the dealing position to lane 0.
- R5: `done` rises only after every lane has emitted its final words and every lane queue is empty. It stays high until the next accepted symbol or flush request. While it is high, `out_valid` is 0.
- R6: Every output word carries its lane number on `out_lane` (0 to N_LANES-1). Words from one lane leave in the order the lane produced them, and no word is lost or duplicated.
- R7: The output side serves non-empty lane queues in rotation, starting at the lane after the last one served. Lane 0 has first turn after reset.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word` and `out_lane` hold their values into the next cycle.
- R9: `sym_ready` is 0 while `flush_req` is high and while a flush is in progress. A `flush_req` given during a flush has no effect.
- R10: `sym_ready` is 0 while the queue of the lane due for the next symbol is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_ready | output | 1 | The offered symbol is taken at this edge |
| sym_data | input | SYM_W | Symbol value |
| flush_req | input | 1 | Request to emit and reset all lane states |
| out_valid | output | 1 | An output word is offered |
| out_ready | input | 1 | The consumer takes the offered word |
| out_word | output | 16 | Output word |
| out_lane | output | LANE_W | Lane that produced `out_word` |
| done | output | 1 | Flush finished and all queues drained |

## Verification
Two events can meet in the same cycle: a flush request and a pending symbol. The bench raises `flush_req` and `sym_valid` on the same edge. It expects the symbol to be refused, which means no model update and `sym_ready` low. After `done`, the next symbol must land in lane 0 with a fresh state. A second meeting happens while the output is stalled: a lane pushing a word while the arbiter is parked on another lane. The bench provokes this with long stretches of `out_ready` low, followed by random draining. A per-lane scoreboard, which keeps order within each lane, judges every word that appears.

// File: rtl/rans_ilv_pkg.sv
// Package: shared constants and types for the interleaved rANS encoder.
// Assumes a 32-bit coder state renormalized in 16-bit words.
package rans_ilv_pkg;
    localparam int WORD_W  = 16;
    localparam int STATE_W = 32;
    localparam logic [STATE_W-1:0] STATE_INIT = 32'h0001_0000;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [STATE_W-1:0] state_t;

    // Flush sequencing phase of a lane
    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_LO   = 2'd1,
        FL_HI   = 2'd2
    } flush_ph_t;
endpackage

// File: rtl/rans_lane_fifo.sv
// Module: per-lane word queue with simultaneous push and pop.
// Assumes the producer never pushes when full and the consumer never pops when empty.
module rans_lane_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Store pushed words
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rans_lane.sv
// Module: behavioural rANS lane with uniform frequencies and flush sequencer.
// Assumes sym_fire only when its queue has room and no flush is running.
module rans_lane
    import rans_ilv_pkg::*;
#(
    parameter int SYM_W     = 4,
    parameter int PROB_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_fire,
    input  logic [SYM_W-1:0] sym,
    input  logic             flush_start,
    input  logic             space,
    output logic             push,
    output word_t            push_word,
    output logic             busy
);
    localparam int     FSH       = PROB_BITS - SYM_W;
    localparam state_t LOW_MASK  = (state_t'(1) << FSH) - state_t'(1);
    localparam state_t EMIT_LIM  = state_t'(1) << (STATE_W - SYM_W);

    state_t    state;
    flush_ph_t phase;
    logic      emit;
    state_t    x_r, x_next;

    // Renormalize, then fold the symbol into the state
    always_comb begin
        emit   = (state >= EMIT_LIM);
        x_r    = emit ? (state >> WORD_W) : state;
        x_next = ((x_r >> FSH) << PROB_BITS) | (state_t'(sym) << FSH) | (x_r & LOW_MASK);
    end

    // Select the word pushed to the lane queue this cycle
    always_comb begin
        push      = 1'b0;
        push_word = state[WORD_W-1:0];
        unique case (phase)
            FL_LO:   push = space;
            FL_HI: begin
                push      = space;
                push_word = state[STATE_W-1:WORD_W];
            end
            default: push = sym_fire && emit;
        endcase
    end

    assign busy = (phase != FL_IDLE);

    // State register and flush sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= STATE_INIT;
            phase <= FL_IDLE;
        end else if (flush_start) begin
            phase <= FL_LO;
        end else begin
            unique case (phase)
                FL_LO: if (space) phase <= FL_HI;
                FL_HI: if (space) begin
                    state <= STATE_INIT;
                    phase <= FL_IDLE;
                end
                default: if (sym_fire) state <= x_next;
            endcase
        end
    end
endmodule

// File: rtl/rans_out_arb.sv
// Module: rotating arbiter that drains lane queues onto one output stream.
// Assumes nonempty is a registered view of the queues; parks on the grant under backpressure.
module rans_out_arb #(
    parameter int N_LANES = 4,
    parameter int LANE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LANES-1:0] nonempty,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [LANE_W-1:0]  grant,
    output logic [N_LANES-1:0] pop
);
    logic [LANE_W-1:0] ptr;

    // Find the first non-empty lane at or after the pointer
    always_comb begin
        int idx;
        grant     = '0;
        out_valid = 1'b0;
        for (int k = 0; k < N_LANES; k++) begin
            idx = (int'(ptr) + k) % N_LANES;
            if (!out_valid && nonempty[idx]) begin
                grant     = LANE_W'(idx);
                out_valid = 1'b1;
            end
        end
    end

    // Pop only the granted lane on a transfer
    always_comb begin
        for (int i = 0; i < N_LANES; i++)
            pop[i] = out_valid && out_ready && (grant == LANE_W'(i));
    end

    // Move past the served lane, or park on it while stalled
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (out_valid) begin
            if (out_ready) ptr <= (grant == LANE_W'(N_LANES-1)) ? '0 : grant + 1'b1;
            else           ptr <= grant;
        end
    end
endmodule

// File: rtl/rans_interleave_enc.sv
// Module: top of the interleaved encoder; deals symbols, runs flush, merges output.
// Assumes PROB_BITS > SYM_W and a consumer that follows valid/ready.
module rans_interleave_enc
    import rans_ilv_pkg::*;
#(
    parameter int N_LANES    = 4,
    parameter int SYM_W      = 4,
    parameter int PROB_BITS  = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int LANE_W    = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    output logic              sym_ready,
    input  logic [SYM_W-1:0]  sym_data,
    input  logic              flush_req,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_word,
    output logic [LANE_W-1:0] out_lane,
    output logic              done
);
    logic [LANE_W-1:0]  in_ptr;
    logic               flushing, done_r;
    logic               sym_fire, flush_start, all_idle;
    logic [N_LANES-1:0] lane_push, lane_busy, q_empty, q_full, q_pop;
    word_t              lane_word [N_LANES];
    word_t              q_head    [N_LANES];

    assign sym_ready   = !flushing && !flush_req && !q_full[in_ptr];
    assign sym_fire    = sym_valid && sym_ready;
    assign flush_start = flush_req && !flushing;
    assign all_idle    = (lane_busy == '0) && (&q_empty);
    assign done        = done_r;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        rans_lane #(.SYM_W(SYM_W), .PROB_BITS(PROB_BITS)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .sym_fire    (sym_fire && (in_ptr == LANE_W'(i))),
            .sym         (sym_data),
            .flush_start (flush_start),
            .space       (!q_full[i]),
            .push        (lane_push[i]),
            .push_word   (lane_word[i]),
            .busy        (lane_busy[i])
        );
        rans_lane_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (lane_push[i]),
            .din   (lane_word[i]),
            .pop   (q_pop[i]),
            .dout  (q_head[i]),
            .empty (q_empty[i]),
            .full  (q_full[i])
        );
    end

    rans_out_arb #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .nonempty  (~q_empty),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .grant     (out_lane),
        .pop       (q_pop)
    );

    assign out_word = q_head[out_lane];

    // Deal symbols in rotation; restart at lane 0 on flush
    always_ff @(posedge clk) begin
        if (!rst_n) in_ptr <= '0;
        else if (flush_start) in_ptr <= '0;
        else if (sym_fire) in_ptr <= (in_ptr == LANE_W'(N_LANES-1)) ? '0 : in_ptr + 1'b1;
    end

    // Track flush progress and the completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flushing <= 1'b0;
            done_r   <= 1'b0;
        end else if (flush_start) begin
            flushing <= 1'b1;
            done_r   <= 1'b0;
        end else if (flushing && all_idle) begin
            flushing <= 1'b0;
            done_r   <= 1'b1;
        end else if (sym_fire) begin
            done_r   <= 1'b0;
        end
    end
endmodule

// File: rtl/rans_interleave_chk.sv
// Module: protocol checker bound to the interleaved encoder top.
// Assumes the port names of rans_interleave_enc.
module rans_interleave_chk #(
    parameter int N_LANES = 4,
    parameter int LANE_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_ready,
    input logic              flush_req,
    input logic              out_valid,
    input logic              out_ready,
    input logic [15:0]       out_word,
    input logic [LANE_W-1:0] out_lane,
    input logic              done
);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_lane));

    // R9
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !sym_ready);

    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R6
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_lane) < N_LANES));

    // R5
    done_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(flush_req));
endmodule

bind rans_interleave_enc rans_interleave_chk #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_ready (sym_ready),
    .flush_req (flush_req),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_lane  (out_lane),
    .done      (done)
);

// File: tb/rans_interleave_enc_test.sv
module rans_interleave_enc_test;
    localparam int N  = 4;
    localparam int SW = 4;
    localparam int PB = 8;
    localparam int LW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0;
    logic [SW-1:0] sym_data = '0;
    logic flush_req = 1'b0;
    logic out_ready = 1'b0;
    logic sym_ready, out_valid, done;
    logic [15:0] out_word;
    logic [LW-1:0] out_lane;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit rdy_rand = 1'b0;
    bit log_on = 1'b0;

    logic [31:0] m_state [N];
    int m_ptr = 0;
    logic [LW+15:0] exp_q [$];
    logic [LW-1:0] lane_log [$];

    bit prev_hold = 1'b0;
    logic [15:0] prev_word;
    logic [LW-1:0] prev_lane;

    rans_interleave_enc #(.N_LANES(N), .SYM_W(SW), .PROB_BITS(PB), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_data(sym_data), .flush_req(flush_req), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_lane(out_lane), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Random consumer backpressure
    always @(posedge clk) begin
        #1;
        if (rdy_rand) out_ready = ($urandom % 3) != 0;
    end

    // Monitor: per-lane scoreboard, hold and done checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold) begin
                check(out_valid && out_word == prev_word && out_lane == prev_lane, "R8",
                      {out_lane, out_word}, {prev_lane, prev_word});
            end
            if (done && out_valid) check(0, "R5 valid while done", 1, 0);
            if (out_valid && out_ready) begin
                int hit = -1;
                foreach (exp_q[i]) if (hit < 0 && exp_q[i][LW+15:16] == out_lane) hit = i;
                if (hit < 0) check(0, "R6 unexpected word", {out_lane, out_word}, 0);
                else begin
                    check(exp_q[hit][15:0] == out_word, "R3/R6 word", out_word, exp_q[hit][15:0]);
                    exp_q.delete(hit);
                end
                if (log_on) lane_log.push_back(out_lane);
            end
            prev_hold = out_valid && !out_ready;
            prev_word = out_word;
            prev_lane = out_lane;
        end
    end

    // Reference encoder step (R2, R3)
    task automatic model_sym(input int s);
        logic [31:0] st = m_state[m_ptr];
        int fr = 1 << (PB - SW);
        if (st >= (32'h1 << (32 - SW))) begin
            exp_q.push_back({LW'(m_ptr), st[15:0]});
            st = st / 65536;
        end
        st = (st / fr) * (1 << PB) + s * fr + (st % fr);
        m_state[m_ptr] = st;
        m_ptr = (m_ptr + 1) % N;
    endtask

    // Reference flush (R4)
    task automatic model_flush();
        for (int i = 0; i < N; i++) exp_q.push_back({LW'(i), m_state[i][15:0]});
        for (int i = 0; i < N; i++) exp_q.push_back({LW'(i), m_state[i][31:16]});
        for (int i = 0; i < N; i++) m_state[i] = 32'h0001_0000;
        m_ptr = 0;
    endtask

    task automatic try_sym(input int s, output bit acc);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_data = SW'(s);
        #1;
        acc = sym_ready;
        if (acc) model_sym(s);
        @(posedge clk);
        #1 sym_valid = 1'b0;
    endtask

    task automatic send_sym(input int s);
        bit acc = 1'b0;
        for (int t = 0; t < 500 && !acc; t++) try_sym(s, acc);
        check(acc, "R10 symbol never taken", 0, 1);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        model_flush();
        #1 check(!sym_ready, "R9 ready during flush_req", sym_ready, 0);
        @(posedge clk);
        #1 flush_req = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            seen = done;
        end
        check(seen, "R5 done", done, 1);
        check(exp_q.size() == 0, "R5 words left", exp_q.size(), 0);
    endtask

    task automatic set_ready(input bit v);
        @(posedge clk);
        #1 rdy_rand = 1'b0;
        out_ready = v;
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_state[i] = 32'h0001_0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(sym_ready == 1'b1, "R1 sym_ready", sym_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(done == 1'b0, "R1 done", done, 0);

        // R7 rotation order after reset, R4 flush of initial states
        log_on = 1'b1;
        do_flush();
        repeat (6) @(negedge clk);
        check(out_valid == 1'b1, "R8 stalled valid", out_valid, 1);
        set_ready(1'b1);
        wait_done();
        log_on = 1'b0;
        check(lane_log.size() == 2 * N, "R7 count", lane_log.size(), 2 * N);
        foreach (lane_log[i])
            check(lane_log[i] == LW'(i % N), "R7 order", lane_log[i], i % N);

        // R2 R3 R6 random stream under random backpressure
        rdy_rand = 1'b1;
        for (int k = 0; k < 200; k++) send_sym($urandom % (1 << SW));
        do_flush();
        wait_done();

        // R5 done persistence and clearing
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R5 done held", done, 1);
        send_sym(7);
        @(negedge clk);
        check(done == 1'b0, "R5 done cleared", done, 0);
        do_flush();
        wait_done();

        // R10 full lane queue blocks input; R9 second flush_req ignored
        begin
            int stalls = 0;
            bit acc;
            set_ready(1'b0);
            for (int k = 0; k < 120; k++) begin
                try_sym(15 - (k % 16), acc);
                if (!acc) stalls++;
            end
            check(stalls > 0, "R10 stall seen", stalls, 1);
            rdy_rand = 1'b1;
            do_flush();
            @(negedge clk);
            flush_req = 1'b1;
            #1 check(!sym_ready, "R9 ready mid flush", sym_ready, 0);
            @(posedge clk);
            #1 flush_req = 1'b0;
            wait_done();
        end

        // R9 flush and symbol in the same cycle; R2 restart at lane 0
        @(negedge clk);
        sym_valid = 1'b1;
        sym_data = 4'h9;
        flush_req = 1'b1;
        model_flush();
        #1 check(!sym_ready, "R9 symbol refused with flush", sym_ready, 0);
        @(posedge clk);
        #1 begin
            flush_req = 1'b0;
            sym_valid = 1'b0;
        end
        wait_done();
        for (int k = 0; k < 9; k++) send_sym(k + 3);
        do_flush();
        wait_done();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule